// File: doc/BRIEF.md
# ECC Fault Status Flag Register

This block keeps the error-correction outcome of reads from a nonvolatile array. The read path delivers one-cycle pulses for three events: a corrected single-bit fault, an uncorrectable double-bit fault, and a collision, where a read that returns invalid data is attempted while the array is busy with a command. The block records these events in two sticky flags. Software reads the flags back over a simple register bus and clears each one by writing 1 to its bit.

A collision has no flag of its own. It is encoded by setting both flags in the same cycle, which a genuine ECC event never does. A configuration input stops corrected single-bit faults from being recorded. Each flag drives its own interrupt request, and a per-flag enable input gates that request. Events reach the register one clock after the read that produced them, through a capture stage.

Top module: `ecc_fsr_top`

## Requirements
- R1: The readback holds the single-fault flag at bit 0 and the double-fault flag at bit 1. Bits from 2 up to DATA_W-1 always read 0, and writes to those bits have no effect.
- R2: While the reset input is low, both flags read 0 and both interrupt outputs are 0.
- R3: A write with `wr_data_i[k]`=1 clears flag k at that clock edge. A write with `wr_data_i[k]`=0 leaves flag k unchanged.
- R4: A single-fault pulse sampled at clock edge E, with `ign_sgl_i`=0, sets bit 0 at edge E+1. Bit 0 is still unchanged right after edge E.
- R5: A double-fault pulse sampled at edge E sets bit 1 at edge E+1. If single-fault and double-fault pulse together without a collision, only bit 1 is set.
- R6: A collision pulse sampled at edge E sets both bit 1 and bit 0 at edge E+1, whatever the value of `ign_sgl_i`.
- R7: A single-fault pulse sampled while `ign_sgl_i`=1 does not set bit 0.
- R8: The flags are sticky. A new event only sets bits and never clears a flag that is already set.
- R9: If a captured set and a write-1 clear reach the same flag at the same edge, the flag ends up set.
- R10: `irq_dbl_o` is bit 1 ANDed with `irq_en_i[1]`. `irq_sgl_o` is bit 0 ANDed with `irq_en_i[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; the block releases it synchronously |
| sgl_fault_i | input | 1 | Pulse: a read corrected a single-bit fault |
| dbl_fault_i | input | 1 | Pulse: a read found an uncorrectable double-bit fault |
| collide_i | input | 1 | Pulse: a read was attempted while a command was running |
| ign_sgl_i | input | 1 | When 1, single-bit faults are not recorded |
| irq_en_i | input | 2 | Interrupt enables: bit 1 for the double-fault flag, bit 0 for the single-fault flag |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | DATA_W | Write data; a 1 clears the matching flag |
| rd_data_o | output | DATA_W | Register readback |
| irq_dbl_o | output | 1 | Double-fault interrupt request |
| irq_sgl_o | output | 1 | Single-fault interrupt request |

## Verification
The bench builds the block with DATA_W=16 and three reset synchronizer stages. The wider word puts fourteen unimplemented bits under the write-ignore and read-zero checks. The deeper synchronizer shows that no result depends on exactly when reset is released. A per-cycle model of the flags, including the one-cycle pending stage, predicts the readback and the interrupts after every edge. This lets the scoreboard catch a wrong latency, a clear that beats a set, and a collision that the ignore input wrongly masks.

// File: rtl/ecc_fsr_pkg.sv
package ecc_fsr_pkg;
  localparam int unsigned NUM_FLAGS = 2;
  localparam int unsigned SGL_POS   = 0;
  localparam int unsigned DBL_POS   = 1;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/ecc_fsr_rst_sync.sv
module ecc_fsr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] sync_q;

  // Reset asserts at once and is released only after STAGES clock edges.
  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= {sync_q[LAST-1:0], 1'b1};
  end

  assign rst_no = sync_q[LAST];
endmodule

// File: rtl/ecc_fsr_capture.sv
module ecc_fsr_capture
  import ecc_fsr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sgl_fault_i,
  input  logic      dbl_fault_i,
  input  logic      collide_i,
  input  logic      ign_sgl_i,
  output flag_vec_t set_o
);
  flag_vec_t set_d;
  flag_vec_t set_q;

  // A collision raises both flags. A parity fault raises one flag only,
  // and the double fault takes precedence over the single fault.
  always_comb begin
    set_d          = '0;
    set_d[DBL_POS] = dbl_fault_i | collide_i;
    set_d[SGL_POS] = collide_i | (sgl_fault_i & ~ign_sgl_i & ~dbl_fault_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) set_q <= '0;
    else         set_q <= set_d;
  end

  assign set_o = set_q;

  // R5: without a collision, the pending stage never holds both sets.
  a_r5_parity_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !collide_i |=> (set_o != 2'b11));

  // R7: a masked single fault leaves no pending single set.
  a_r7_ignore_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sgl_fault_i && ign_sgl_i && !collide_i) |=> !set_o[SGL_POS]);
endmodule

// File: rtl/ecc_fsr_flags.sv
module ecc_fsr_flags
  import ecc_fsr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  flag_vec_t set_i,
  input  logic      wr_en_i,
  input  flag_vec_t wr_bits_i,
  output flag_vec_t flags_o
);
  flag_vec_t flag_q;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    logic clr;
    logic flag_d;
    logic flag_en;

    always_comb begin
      clr     = wr_en_i & wr_bits_i[g];
      flag_en = set_i[g] | clr;
      // The set term is ORed in last, so a set wins over a clear.
      flag_d  = set_i[g] | (flag_q[g] & ~clr);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      flag_q[g] <= 1'b0;
      else if (flag_en) flag_q[g] <= flag_d;
    end

    // R9: a pending set always leaves the flag high, even with a clear.
    a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_q[g]);

    // R3: without a set or a write-1 clear, the flag holds its value.
    a_r3_hold_without_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i[g] && !(wr_en_i && wr_bits_i[g])) |=> (flag_q[g] == $past(flag_q[g])));
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/ecc_fsr_top.sv
module ecc_fsr_top
  import ecc_fsr_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sgl_fault_i,
  input  logic              dbl_fault_i,
  input  logic              collide_i,
  input  logic              ign_sgl_i,
  input  logic [1:0]        irq_en_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_dbl_o,
  output logic              irq_sgl_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_FLAGS;

  logic      rst_n_s;
  flag_vec_t set_q;
  flag_vec_t flags;
  logic      unused_wr_hi;

  ecc_fsr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_n_s)
  );

  ecc_fsr_capture u_capture (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_s),
    .sgl_fault_i (sgl_fault_i),
    .dbl_fault_i (dbl_fault_i),
    .collide_i   (collide_i),
    .ign_sgl_i   (ign_sgl_i),
    .set_o       (set_q)
  );

  ecc_fsr_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .set_i     (set_q),
    .wr_en_i   (wr_en_i),
    .wr_bits_i (wr_data_i[NUM_FLAGS-1:0]),
    .flags_o   (flags)
  );

  // The unimplemented write bits are dropped on purpose.
  assign unused_wr_hi = ^wr_data_i[DATA_W-1:NUM_FLAGS];

  assign rd_data_o = {{PAD_W{1'b0}}, flags};
  assign irq_dbl_o = flags[DBL_POS] & irq_en_i[1];
  assign irq_sgl_o = flags[SGL_POS] & irq_en_i[0];

  // R1: the unimplemented bits always read as zero.
  a_r1_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    rd_data_o[DATA_W-1:NUM_FLAGS] == '0);

  // R4: an unmasked single fault shows at bit 0 one clock after capture.
  a_r4_single_latency: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (sgl_fault_i && !ign_sgl_i && !dbl_fault_i) |=> ##1 rd_data_o[SGL_POS]);

  // R6: a collision sets both flags one clock after capture.
  a_r6_collision_both: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    collide_i |=> ##1 (rd_data_o[NUM_FLAGS-1:0] == 2'b11));

  // R10: a disabled interrupt never asserts.
  a_r10_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (!irq_en_i[1] |-> !irq_dbl_o) and (!irq_en_i[0] |-> !irq_sgl_o));
endmodule

// File: tb/ecc_fsr_top_tb.sv
module ecc_fsr_top_tb;
  localparam int DW = 16;
  localparam int SS = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sgl, dbl, col, ign, we;
  logic [1:0]    en;
  logic [DW-1:0] wd;
  logic [DW-1:0] rd;
  logic          irq_d, irq_s;

  always #2 clk = ~clk;  // 250 MHz

  ecc_fsr_top #(.DATA_W(DW), .SYNC_STAGES(SS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sgl_fault_i(sgl), .dbl_fault_i(dbl),
    .collide_i(col), .ign_sgl_i(ign), .irq_en_i(en), .wr_en_i(we),
    .wr_data_i(wd), .rd_data_o(rd), .irq_dbl_o(irq_d), .irq_sgl_o(irq_s)
  );

  typedef struct {
    int            due;
    logic [DW-1:0] rd;
    logic [1:0]    irq;
    string         tag;
  } exp_t;

  exp_t       sb_q[$];
  int         cyc = 0;
  int         checks = 0;
  int         fails = 0;
  bit         mon_on = 1'b0;
  bit         done = 1'b0;
  logic [1:0] m_flags = 2'b00;
  logic [1:0] m_pend = 2'b00;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected result.
  task automatic step(input logic s, input logic d, input logic c, input logic ig,
                      input logic w, input logic [DW-1:0] data, input logic [1:0] ie,
                      input string tag);
    logic [1:0] clr;
    logic [1:0] nf;
    exp_t       e;
    @(negedge clk);
    sgl = s; dbl = d; col = c; ign = ig; we = w; wd = data; en = ie;
    clr     = w ? data[1:0] : 2'b00;
    nf      = (m_flags & ~clr) | m_pend;       // a set beats a clear at the same edge
    m_pend  = {d | c, c | (s & ~ig & ~d)};
    m_flags = nf;
    e.due = cyc + 1;
    e.rd  = {{(DW-2){1'b0}}, nf};
    e.irq = nf & ie;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n, input logic [1:0] ie, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, '0, ie, tag);
  endtask

  // Monitor: pops and compares the expected items once the design produces them.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (mon_on && sb_q.size() > 0 && sb_q[0].due <= cyc) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (e.due != cyc || rd !== e.rd || {irq_d, irq_s} !== e.irq) begin
          fails++;
          $display("FAIL %s: rd=%h irq=%b expected rd=%h irq=%b", e.tag, rd,
                   {irq_d, irq_s}, e.rd, e.irq);
        end
      end
    end
  end

  task automatic check_reset(input string tag);
    @(negedge clk);
    checks++;
    if (rd !== '0 || irq_d !== 1'b0 || irq_s !== 1'b0) begin
      fails++;
      $display("FAIL %s: rd=%h irq=%b expected rd=0 irq=00", tag, rd, {irq_d, irq_s});
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    report();
  end

  initial begin
    rst_n = 1'b0; sgl = 0; dbl = 0; col = 0; ign = 0; we = 0; wd = '0; en = 2'b11;
    repeat (3) check_reset("R2");
    @(negedge clk);
    rst_n  = 1'b1;
    mon_on = 1'b1;
    idle(6, 2'b11, "R2");

    // R4: single fault, one-clock latency through the capture stage.
    step(1, 0, 0, 0, 0, '0, 2'b11, "R4");
    idle(3, 2'b11, "R4");

    // R3: a write of 0 holds the flag, a write of 1 clears it.
    step(0, 0, 0, 0, 1, 16'h0000, 2'b11, "R3");
    step(0, 0, 0, 0, 1, 16'h0001, 2'b11, "R3");
    idle(2, 2'b11, "R3");

    // R7: a single fault with the ignore input high is not recorded.
    step(1, 0, 0, 1, 0, '0, 2'b11, "R7");
    idle(3, 2'b11, "R7");

    // R5: a double fault alone, then single and double pulsed together.
    step(0, 1, 0, 0, 0, '0, 2'b11, "R5");
    idle(2, 2'b11, "R5");
    step(0, 0, 0, 0, 1, 16'h0002, 2'b11, "R5");
    step(1, 1, 0, 0, 0, '0, 2'b11, "R5");
    idle(3, 2'b11, "R5");

    // R8: a single fault adds to the standing double flag.
    step(1, 0, 0, 0, 0, '0, 2'b11, "R8");
    idle(2, 2'b11, "R8");
    step(0, 1, 0, 0, 0, '0, 2'b11, "R8");
    idle(2, 2'b11, "R8");

    // R1: an all-ones write clears both flags, and the upper bits stay zero.
    step(0, 0, 0, 0, 1, 16'hFFFF, 2'b11, "R1");
    idle(2, 2'b11, "R1");
    step(0, 0, 0, 0, 1, 16'hFFFC, 2'b11, "R1");
    idle(2, 2'b11, "R1");

    // R6: a collision sets both flags even when the ignore input is high.
    step(0, 0, 1, 1, 0, '0, 2'b11, "R6");
    idle(3, 2'b11, "R6");
    step(0, 0, 0, 0, 1, 16'h0003, 2'b11, "R6");
    idle(2, 2'b11, "R6");

    // R9: a pending set meets a write-1 clear at the same edge.
    step(1, 0, 0, 0, 0, '0, 2'b11, "R9");
    step(0, 0, 0, 0, 1, 16'h0001, 2'b11, "R9");
    idle(2, 2'b11, "R9");
    step(0, 1, 0, 0, 0, '0, 2'b11, "R9");
    step(0, 0, 0, 0, 1, 16'h0003, 2'b11, "R9");
    idle(2, 2'b11, "R9");

    // R10: the interrupt enables gate each flag separately.
    idle(2, 2'b00, "R10");
    idle(2, 2'b10, "R10");
    idle(2, 2'b01, "R10");
    step(0, 0, 0, 0, 1, 16'h0002, 2'b11, "R10");
    idle(2, 2'b11, "R10");

    // R2: a reset in the middle of the run clears the flags that are set.
    step(0, 0, 1, 0, 0, '0, 2'b11, "R2");
    idle(3, 2'b11, "R2");
    mon_on = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    check_reset("R2");
    check_reset("R2");
    report();
  end
endmodule